// File: doc/BRIEF.md
# Serial Receive Clock and Frame-Sync Front-End

This block sits at the receive edge of a synchronous serial port. It chooses which clock the receiver runs on, drives the clock pin when that pin is an output, applies the programmable clock and frame-sync polarities, and captures serial words. All logic runs on one fast system clock. The serial clocks arrive as slow level signals and are oversampled, and their edges are found by comparing successive samples.

The receive clock comes from one of three places: the clock pin, the internal sample-rate clock, or the internal transmit clock. A loopback bit and a clock-mode bit make the choice and also set the pin direction. Clock polarity is normalised so that data and external frame sync are always captured on the falling edge of the internal receive clock. A frame sync may come in from a pin or go out to it. Each detected frame sync starts a word of programmable length, shifted in MSB first, and a one-cycle valid strobe follows the last bit.

Top module: `rxfe_top`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_out` is 0.
- R2: With `cfg_loopback`=0 and `cfg_clk_mode`=0, the internal clock level `rx_clk_lvl` equals `pin_clk_in` XOR `cfg_clk_pol`, and `clk_pin_oe` is 0.
- R3: With `cfg_loopback`=1 and `cfg_clk_mode`=0, `rx_clk_lvl` follows `tx_clk`, and `clk_pin_oe` is 0 (the pin floats).
- R4: With `cfg_loopback`=0 and `cfg_clk_mode`=1, `rx_clk_lvl` follows `srg_clk`, `clk_pin_oe` is 1, and `clk_pin_out` equals `srg_clk` XOR `cfg_clk_pol`.
- R5: With `cfg_loopback`=1 and `cfg_clk_mode`=1, `rx_clk_lvl` follows `tx_clk`, `clk_pin_oe` is 1, and `clk_pin_out` equals `tx_clk` XOR `cfg_clk_pol`.
- R6: `data_in` and the frame sync are captured on the falling edge of `rx_clk_lvl`. With `cfg_clk_pol`=1 and the pin as the source, this is the rising edge of the pin.
- R7: With `cfg_fs_out`=0, the internal frame sync is `fs_pin_in` XOR `cfg_fs_pol` (active high inside), and `fs_pin_oe` and `fs_pin_out` are 0.
- R8: With `cfg_fs_out`=1, `fs_gen` is registered on each rising edge of `rx_clk_lvl`. That register is the internal frame sync, `fs_pin_oe` is 1, and `fs_pin_out` is the register XOR `cfg_fs_pol`.
- R9: A frame sync seen on a falling edge starts a word of `cfg_word_len`+1 bits (field value 0 to 31 gives 1 to 32 bits). The bit taken on that same edge is the MSB. One cycle-wide `word_valid` pulse follows the last bit, with the word right-justified in `word_out`.
- R10: A frame sync that arrives in the middle of a word drops the partial word and starts a new one, with no `word_valid` for the dropped word.
- R11: Toggling the clock sources that are not selected, and the frame-sync input that is not in use, has no effect on `rx_clk_lvl` or on captured words.
- R12: Whenever `clk_pin_oe` is 0, `clk_pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loopback | input | 1 | Take the clock from the transmit side |
| cfg_clk_mode | input | 1 | Clock pin is an output when 1 |
| cfg_clk_pol | input | 1 | Receive clock polarity |
| cfg_fs_out | input | 1 | Frame sync is driven out when 1 |
| cfg_fs_pol | input | 1 | Frame-sync pin is active low when 1 |
| cfg_word_len | input | LEN_W | Word length minus one |
| pin_clk_in | input | 1 | Clock pin input level |
| srg_clk | input | 1 | Internal sample-rate clock level |
| tx_clk | input | 1 | Internal transmit clock level |
| fs_pin_in | input | 1 | Frame-sync pin input level |
| fs_gen | input | 1 | Internal frame-sync request, active high |
| data_in | input | 1 | Serial receive data |
| rx_clk_lvl | output | 1 | Selected internal receive clock level |
| clk_pin_oe | output | 1 | Clock pin output enable |
| clk_pin_out | output | 1 | Clock pin output value |
| fs_pin_oe | output | 1 | Frame-sync pin output enable |
| fs_pin_out | output | 1 | Frame-sync pin output value |
| word_out | output | WORD_MAX | Last complete word, right-justified |
| word_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The hardest case to reach from the ports is a new frame sync that lands while a word is still being shifted in. It only matters when the remaining bit count has not yet run out, and under a wrong polarity setting it can look the same as a normal frame start. The bench sends a deliberately short partial frame and follows it at once with a full frame. It checks that exactly one word comes out, and that this word is the second frame's. Random frames mix every clock source, both polarities, both frame-sync directions and lengths from 1 to 32 bits, while the unselected sources toggle at random.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

    typedef enum logic [1:0] {
        SRC_PIN = 2'd0,
        SRC_SRG = 2'd1,
        SRC_TX  = 2'd2
    } rclk_src_e;

    typedef struct packed {
        logic level;
        logic pin_oe;
        logic pin_out;
    } clk_route_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic rclk_src_e pick_src(input logic loopback, input logic mode);
        if (loopback)
            return SRC_TX;
        else if (mode)
            return SRC_SRG;
        else
            return SRC_PIN;
    endfunction

endpackage

// File: rtl/rxfe_clk_mux.sv
module rxfe_clk_mux
    import rxfe_pkg::*;
(
    input  logic       cfg_loopback,
    input  logic       cfg_clk_mode,
    input  logic       cfg_clk_pol,
    input  logic       pin_clk_in,
    input  logic       srg_clk,
    input  logic       tx_clk,
    output clk_route_t route
);
    rclk_src_e src;

    always_comb begin
        src           = pick_src(cfg_loopback, cfg_clk_mode);
        route.pin_oe  = cfg_clk_mode;
        route.pin_out = 1'b0;
        unique case (src)
            SRC_SRG: route.level = srg_clk;
            SRC_TX:  route.level = tx_clk;
            default: route.level = pin_clk_in ^ cfg_clk_pol;
        endcase
        if (cfg_clk_mode)
            route.pin_out = route.level ^ cfg_clk_pol;
    end
endmodule

// File: rtl/rxfe_edge_det.sv
module rxfe_edge_det
    import rxfe_pkg::*;
#(
    parameter int SIDE_W = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl,
    input  logic [SIDE_W-1:0] side_in,
    output edge_t             edges,
    output logic [SIDE_W-1:0] side_q
);
    logic lvl_q1, lvl_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q1 <= 1'b0;
            lvl_q2 <= 1'b0;
            side_q <= '0;
        end else begin
            lvl_q1 <= lvl;
            lvl_q2 <= lvl_q1;
            side_q <= side_in;
        end
    end

    always_comb begin
        edges.rise = lvl_q1 & ~lvl_q2;
        edges.fall = lvl_q2 & ~lvl_q1;
    end
endmodule

// File: rtl/rxfe_fsync.sv
module rxfe_fsync
    import rxfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_t edges,
    input  logic  cfg_fs_out,
    input  logic  cfg_fs_pol,
    input  logic  fs_pin_q,
    input  logic  fs_gen,
    output logic  fs_int,
    output logic  fs_pin_oe,
    output logic  fs_pin_out
);
    logic gen_q;

    always_ff @(posedge clk) begin
        if (rst)
            gen_q <= 1'b0;
        else if (edges.rise)
            gen_q <= fs_gen;
    end

    always_comb begin
        fs_pin_oe  = cfg_fs_out;
        fs_pin_out = cfg_fs_out & (gen_q ^ cfg_fs_pol);
        fs_int     = cfg_fs_out ? gen_q : (fs_pin_q ^ cfg_fs_pol);
    end
endmodule

// File: rtl/rxfe_shifter.sv
module rxfe_shifter #(
    parameter int WORD_MAX = 32,
    localparam int LEN_W = $clog2(WORD_MAX)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                fall,
    input  logic                fs_int,
    input  logic                bit_in,
    input  logic [LEN_W-1:0]    cfg_word_len,
    output logic [WORD_MAX-1:0] word_out,
    output logic                word_valid
);
    logic [WORD_MAX-1:0] shreg, sh_next;
    logic [LEN_W-1:0]    idx, idx_next;
    logic                busy, take, done;

    always_comb begin
        take     = fall & (fs_int | busy);
        idx_next = fs_int ? '0 : idx + 1'b1;
        sh_next  = fs_int ? {{(WORD_MAX-1){1'b0}}, bit_in}
                          : {shreg[WORD_MAX-2:0], bit_in};
        done     = take & (idx_next == cfg_word_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            idx        <= '0;
            busy       <= 1'b0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= done;
            if (take) begin
                shreg <= sh_next;
                idx   <= idx_next;
                busy  <= ~done;
            end
            if (done)
                word_out <= sh_next;
        end
    end
endmodule

// File: rtl/rxfe_top.sv
module rxfe_top
    import rxfe_pkg::*;
#(
    parameter int WORD_MAX = 32,
    localparam int LEN_W = $clog2(WORD_MAX)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_loopback,
    input  logic                cfg_clk_mode,
    input  logic                cfg_clk_pol,
    input  logic                cfg_fs_out,
    input  logic                cfg_fs_pol,
    input  logic [LEN_W-1:0]    cfg_word_len,
    input  logic                pin_clk_in,
    input  logic                srg_clk,
    input  logic                tx_clk,
    input  logic                fs_pin_in,
    input  logic                fs_gen,
    input  logic                data_in,
    output logic                rx_clk_lvl,
    output logic                clk_pin_oe,
    output logic                clk_pin_out,
    output logic                fs_pin_oe,
    output logic                fs_pin_out,
    output logic [WORD_MAX-1:0] word_out,
    output logic                word_valid
);
    localparam int SIDE_W = 2;

    clk_route_t        route;
    edge_t             edg;
    logic [SIDE_W-1:0] side_q;
    logic              fs_int;

    rxfe_clk_mux i_mux (
        .cfg_loopback (cfg_loopback),
        .cfg_clk_mode (cfg_clk_mode),
        .cfg_clk_pol  (cfg_clk_pol),
        .pin_clk_in   (pin_clk_in),
        .srg_clk      (srg_clk),
        .tx_clk       (tx_clk),
        .route        (route)
    );

    assign rx_clk_lvl  = route.level;
    assign clk_pin_oe  = route.pin_oe;
    assign clk_pin_out = route.pin_out;

    rxfe_edge_det #(.SIDE_W(SIDE_W)) i_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl     (route.level),
        .side_in ({fs_pin_in, data_in}),
        .edges   (edg),
        .side_q  (side_q)
    );

    rxfe_fsync i_fs (
        .clk        (clk),
        .rst        (rst),
        .edges      (edg),
        .cfg_fs_out (cfg_fs_out),
        .cfg_fs_pol (cfg_fs_pol),
        .fs_pin_q   (side_q[1]),
        .fs_gen     (fs_gen),
        .fs_int     (fs_int),
        .fs_pin_oe  (fs_pin_oe),
        .fs_pin_out (fs_pin_out)
    );

    rxfe_shifter #(.WORD_MAX(WORD_MAX)) i_shift (
        .clk          (clk),
        .rst          (rst),
        .fall         (edg.fall),
        .fs_int       (fs_int),
        .bit_in       (side_q[0]),
        .cfg_word_len (cfg_word_len),
        .word_out     (word_out),
        .word_valid   (word_valid)
    );
endmodule

// File: rtl/rxfe_checker.sv
module rxfe_checker (
    input logic clk,
    input logic rst,
    input logic cfg_loopback,
    input logic cfg_clk_mode,
    input logic cfg_clk_pol,
    input logic cfg_fs_out,
    input logic tx_clk,
    input logic clk_pin_oe,
    input logic clk_pin_out,
    input logic fs_pin_oe,
    input logic fs_pin_out,
    input logic fall_stb,
    input logic word_valid
);
    AST_LOOP_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (cfg_loopback && !cfg_clk_mode) |-> !clk_pin_oe); // R3

    AST_LOOP_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (cfg_loopback && cfg_clk_mode) |-> (clk_pin_oe && clk_pin_out == (tx_clk ^ cfg_clk_pol))); // R5

    AST_FS_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg_fs_out |-> (!fs_pin_oe && !fs_pin_out)); // R7

    AST_FS_OUT_EN: assert property (@(posedge clk) disable iff (rst)
        cfg_fs_out |-> fs_pin_oe); // R8

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(fall_stb)); // R6

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R9

    AST_PIN_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !clk_pin_oe |-> !clk_pin_out); // R12
endmodule

bind rxfe_top rxfe_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_loopback (cfg_loopback),
    .cfg_clk_mode (cfg_clk_mode),
    .cfg_clk_pol  (cfg_clk_pol),
    .cfg_fs_out   (cfg_fs_out),
    .tx_clk       (tx_clk),
    .clk_pin_oe   (clk_pin_oe),
    .clk_pin_out  (clk_pin_out),
    .fs_pin_oe    (fs_pin_oe),
    .fs_pin_out   (fs_pin_out),
    .fall_stb     (edg.fall),
    .word_valid   (word_valid)
);

// File: tb/test_rxfe_top.sv
`timescale 1ns/1ps
module test_rxfe_top;
    localparam int WORD_MAX = 32;
    localparam int LEN_W = $clog2(WORD_MAX);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_loopback = 0, cfg_clk_mode = 0, cfg_clk_pol = 0, cfg_fs_out = 0, cfg_fs_pol = 0;
    logic [LEN_W-1:0] cfg_word_len = '0;
    logic pin_clk_in = 0, srg_clk = 0, tx_clk = 0, fs_pin_in = 0, fs_gen = 0, data_in = 0;
    logic rx_clk_lvl, clk_pin_oe, clk_pin_out, fs_pin_oe, fs_pin_out, word_valid;
    logic [WORD_MAX-1:0] word_out;

    int n_vec = 0, n_bad = 0, n_valid = 0;
    logic [31:0] exp_word = '0;
    bit noise = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxfe_top #(.WORD_MAX(WORD_MAX)) i_rxfe_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_lvl();
        if (cfg_loopback) return tx_clk;
        if (cfg_clk_mode) return srg_clk;
        return pin_clk_in ^ cfg_clk_pol;
    endfunction

    function automatic logic exp_pin();
        if (!cfg_clk_mode) return 1'b0;
        return (cfg_loopback ? tx_clk : srg_clk) ^ cfg_clk_pol;
    endfunction

    function automatic logic [31:0] len_mask(input int len);
        logic [63:0] m = (64'd1 << len) - 64'd1;
        return m[31:0];
    endfunction

    task automatic drive_int(input logic lvl);
        if (noise) begin
            pin_clk_in = 1'($urandom);
            srg_clk    = 1'($urandom);
            tx_clk     = 1'($urandom);
        end
        if (cfg_loopback)      tx_clk = lvl;
        else if (cfg_clk_mode) srg_clk = lvl;
        else                   pin_clk_in = lvl ^ cfg_clk_pol;
    endtask

    task automatic check_pins();
        string rq;
        rq = cfg_loopback ? (cfg_clk_mode ? "R5" : "R3") : (cfg_clk_mode ? "R4" : "R2");
        chk({rq, " level"}, {31'd0, rx_clk_lvl}, {31'd0, exp_lvl()});
        chk({rq, " oe"}, {31'd0, clk_pin_oe}, {31'd0, cfg_clk_mode});
        chk("R12 pin value", {31'd0, clk_pin_out}, {31'd0, exp_pin()});
        if (!cfg_fs_out)
            chk("R7 fs pin idle", {30'd0, fs_pin_oe, fs_pin_out}, 32'd0);
    endtask

    task automatic set_cfg(input logic lb, input logic md, input logic cp,
                           input logic fo, input logic fp, input int len);
        @(negedge clk);
        cfg_loopback = lb; cfg_clk_mode = md; cfg_clk_pol = cp;
        cfg_fs_out = fo; cfg_fs_pol = fp; cfg_word_len = LEN_W'(len - 1);
        fs_gen = 1'b0; fs_pin_in = fp;
        drive_int(1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic send_bits(input int len, input logic [31:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            logic fsl;
            fsl = (i == 0);
            @(negedge clk);
            data_in = w[len-1-i];
            if (cfg_fs_out) begin
                fs_gen = fsl;
                if (noise) fs_pin_in = 1'($urandom);
            end else begin
                fs_pin_in = fsl ^ cfg_fs_pol;
                if (noise) fs_gen = 1'($urandom);
            end
            drive_int(1'b1);
            #1 check_pins();
            repeat (4) @(negedge clk);
            if (cfg_fs_out)
                chk("R8 fs out", {30'd0, fs_pin_oe, fs_pin_out}, {30'd0, 1'b1, fsl ^ cfg_fs_pol});
            drive_int(1'b0);
            #1 check_pins();
            repeat (4) @(negedge clk);
        end
        fs_gen = 1'b0;
        fs_pin_in = cfg_fs_pol;
    endtask

    task automatic run_frame(input string req, input int len, input logic [31:0] w);
        int v0;
        v0 = n_valid;
        exp_word = w & len_mask(len);
        send_bits(len, w, len);
        repeat (4) @(negedge clk);
        chk({req, " word count"}, n_valid - v0, 1);
    endtask

    always @(negedge clk) begin
        if (!rst && word_valid) begin
            n_valid++;
            chk("R9 word value", word_out, exp_word);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", {31'd0, word_valid}, 32'd0);
        chk("R1 reset word", word_out, 32'd0);

        set_cfg(0, 0, 0, 0, 0, 8);
        run_frame("R6 pin fall", 8, 32'hA5);
        set_cfg(0, 0, 1, 0, 0, 8);
        run_frame("R6 pin rise", 8, 32'h3C);
        set_cfg(1, 0, 0, 0, 1, 1);
        run_frame("R7 low fs len1", 1, 32'h1);
        set_cfg(0, 1, 1, 1, 1, 32);
        run_frame("R8 len32", 32, 32'hDEADBEEF);

        set_cfg(1, 1, 0, 0, 0, 12);
        begin
            int v0;
            v0 = n_valid;
            send_bits(12, 32'hFFF, 5);
            exp_word = 32'h5A3;
            send_bits(12, 32'h5A3, 12);
            repeat (4) @(negedge clk);
            chk("R10 restart count", n_valid - v0, 1);
        end

        noise = 1'b1;
        for (int k = 0; k < 24; k++) begin
            int len;
            len = 1 + int'($urandom_range(0, 31));
            if (k == 0) len = 1;
            if (k == 1) len = 32;
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), len);
            run_frame("R11 random", len, $urandom);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule